// File: doc/BRIEF.md
# Card Feed Ready Supervisor

This block decides when a card-feeding peripheral reports itself ready to its host controller. The host may start a feed cycle only while the ready output is high. Ready comes from media and station status levels. Two sticky registers can take it away: a fault register, which also lights the feed lamp and asks for the motor to stop, and a stop register. Several switch levels force it low while they are present. Ready also drops at the end of every feed cycle, when the end-of-cycle and resume pulses arrive together.

The front-panel ready pushbutton also acts as the master clear, after a debounce filter. A power-on timer keeps the same clear active for a fixed time after reset is released. While the clear is active, the clear output is high and every register of the block is emptied. Start requests that arrive while ready is low have no effect on the feed. Each one raises a sticky protocol-error flag that the host side can inspect. All inputs are already synchronised to the clock. The filter and power-on durations are parameters in clock cycles.

Top module: `feed_ready_supervisor`

## Requirements
- R1: `ready` becomes 1 one clock after a cycle in which all of these hold: `hopper_loaded`=1, `stacker_full`=0, `stn1_flag`=1, `stn12_flag`=1, `fault`=0 and `clear_out`=0. Once set, it holds until R2 or R3 removes it; none of these media or station levels removes it alone.
- R2: A cycle with both `cycle_end`=1 and `resume`=1 makes `ready` 0 one clock later, even if the R1 conditions hold in that cycle. Either pulse alone has no effect.
- R3: `ready` becomes 0 one clock after a cycle with any of these: `fault`=1, `manual_mode`=1, the stop register set, `clear_out`=1, `read_en_fail`=1, `motor_power_on`=0 or `interlock_closed`=0.
- R4: `fault` becomes 1 one clock after a cycle with `interlock_closed`=0 or `card_stuck`=1. It then stays 1 until a clear. `motor_stop_req` always equals `fault`.
- R5: A `stop_req` pulse sets a stop register. This register keeps `ready` low until a clear empties it.
- R6: The debounced button level takes the value of `ready_btn_raw` at the DEB_CYCLES-th consecutive clock edge at which the raw level differs from it. A shorter press has no effect on `clear_out`.
- R7: `clear_out` is 1 while the debounced button is pressed. One clock after any cycle with `clear_out`=1, `fault`, `proto_err`, `ready` and the stop register are 0. Ready may set again after release.
- R8: Reset (`rst_n`=0) makes `clear_out` 1 and `ready`, `fault` and `proto_err` 0. After release, `clear_out` stays 1 for exactly POR_CYCLES clock edges.
- R9: `start_req`=1 in a cycle with `ready`=0 sets `proto_err` one clock later, and it stays set until a clear. `start_req` with `ready`=1 leaves `proto_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hopper_loaded | input | 1 | Input hopper contains cards |
| stacker_full | input | 1 | Output stacker is full |
| stn1_flag | input | 1 | Card is present at the first station |
| stn12_flag | input | 1 | Card has moved from station 1 toward station 2 |
| manual_mode | input | 1 | Maintenance manual mode switch |
| read_en_fail | input | 1 | Read enable failure flag |
| motor_power_on | input | 1 | Motor power switch is on |
| interlock_closed | input | 1 | Interlock circuit is closed |
| card_stuck | input | 1 | Pulse: a card did not leave station 1 in time |
| stop_req | input | 1 | Pulse: sets the stop register |
| ready_btn_raw | input | 1 | Raw ready pushbutton level, 1 = pressed |
| cycle_end | input | 1 | End-of-feed-cycle pulse |
| resume | input | 1 | Resume pulse |
| start_req | input | 1 | Start request from the host |
| ready | output | 1 | Ready level to the host |
| fault | output | 1 | Fault register; drives the feed lamp |
| motor_stop_req | output | 1 | Motor shutdown request |
| clear_out | output | 1 | Master clear to other logic |
| proto_err | output | 1 | Sticky flag: start request while not ready |

## Verification
Two events can fall in the same cycle: the cycle-end drop, and an active set condition for ready. The same holds for a fault trigger or stop pulse and an active master clear. Holding the R1 conditions high while pulsing `cycle_end` and `resume` together provokes the first pair, both in a directed step and often in the random phase. The random phase also presses the button while the interlock and stuck-card inputs toggle. At the falling edge after each clock, a cycle-accurate model of the requirements in the bench judges which event wins: the drop over the set, and the clear over a new fault, stop or protocol error.

// File: rtl/feed_ready_supervisor.sv
module feed_ready_supervisor #(
  parameter int DEB_CYCLES = 250_000,
  parameter int POR_CYCLES = 15_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hopper_loaded,
  input  logic stacker_full,
  input  logic stn1_flag,
  input  logic stn12_flag,
  input  logic manual_mode,
  input  logic read_en_fail,
  input  logic motor_power_on,
  input  logic interlock_closed,
  input  logic card_stuck,
  input  logic stop_req,
  input  logic ready_btn_raw,
  input  logic cycle_end,
  input  logic resume,
  input  logic start_req,
  output logic ready,
  output logic fault,
  output logic motor_stop_req,
  output logic clear_out,
  output logic proto_err
);

  localparam int DW = $clog2(DEB_CYCLES + 1);
  localparam int PW = $clog2(POR_CYCLES + 1);
  localparam logic [DW-1:0] DEB_LAST = DW'(DEB_CYCLES - 1);
  localparam logic [PW-1:0] POR_DONE = PW'(POR_CYCLES);

  logic [DW-1:0] deb_cnt;
  logic [PW-1:0] por_cnt;
  logic btn_db, stop_q, por_on;
  logic may_set, must_drop;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      deb_cnt <= '0;
      btn_db  <= 1'b0;
    end else if (ready_btn_raw == btn_db) begin
      deb_cnt <= '0;
    end else if (deb_cnt == DEB_LAST) begin
      deb_cnt <= '0;
      btn_db  <= ready_btn_raw;
    end else begin
      deb_cnt <= deb_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) por_cnt <= '0;
    else if (por_cnt != POR_DONE) por_cnt <= por_cnt + 1'b1;

  assign por_on    = (por_cnt != POR_DONE);
  assign clear_out = por_on | btn_db;

  assign may_set = hopper_loaded & ~stacker_full & stn1_flag & stn12_flag
                 & ~(fault | clear_out);
  assign must_drop = fault | manual_mode | stop_q | clear_out | read_en_fail
                   | ~motor_power_on | ~interlock_closed | (cycle_end & resume);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ready     <= 1'b0;
      fault     <= 1'b0;
      stop_q    <= 1'b0;
      proto_err <= 1'b0;
    end else if (clear_out) begin
      ready     <= 1'b0;
      fault     <= 1'b0;
      stop_q    <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      if (must_drop)    ready <= 1'b0;
      else if (may_set) ready <= 1'b1;
      if (~interlock_closed | card_stuck) fault <= 1'b1;
      if (stop_req) stop_q <= 1'b1;
      if (start_req & ~ready) proto_err <= 1'b1;
    end

  assign motor_stop_req = fault;

endmodule

// File: rtl/feed_ready_supervisor_chk.sv
module feed_ready_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic hopper_loaded,
  input logic stacker_full,
  input logic stn1_flag,
  input logic stn12_flag,
  input logic manual_mode,
  input logic cycle_end,
  input logic resume,
  input logic start_req,
  input logic stop_q,
  input logic ready,
  input logic fault,
  input logic clear_out,
  input logic proto_err
);

  AST_READY_NEEDS_MEDIA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(hopper_loaded && !stacker_full && stn1_flag && stn12_flag)); // R1

  AST_CYCLE_END_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && resume) |=> !ready); // R2

  AST_MANUAL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    manual_mode |=> !ready); // R3

  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !ready); // R4

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clear_out) |=> fault); // R4

  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !clear_out) |=> (stop_q && !ready)); // R5

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_out |=> (!ready && !fault && !proto_err && !stop_q)); // R7

  AST_START_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !ready && !clear_out) |=> proto_err); // R9

endmodule

bind feed_ready_supervisor feed_ready_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hopper_loaded(hopper_loaded), .stacker_full(stacker_full),
  .stn1_flag(stn1_flag), .stn12_flag(stn12_flag), .manual_mode(manual_mode),
  .cycle_end(cycle_end), .resume(resume), .start_req(start_req), .stop_q(stop_q),
  .ready(ready), .fault(fault), .clear_out(clear_out), .proto_err(proto_err)
);

// File: tb/test_feed_ready_supervisor.sv
module test_feed_ready_supervisor;
  localparam int DEB = 4;
  localparam int POR = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hopper_loaded = 1, stacker_full = 0, stn1_flag = 1, stn12_flag = 1;
  logic manual_mode = 0, read_en_fail = 0, motor_power_on = 1, interlock_closed = 1;
  logic card_stuck = 0, stop_req = 0, ready_btn_raw = 0;
  logic cycle_end = 0, resume = 0, start_req = 0;
  logic ready, fault, motor_stop_req, clear_out, proto_err;

  int checks = 0, fails = 0, wd = 0;

  // model state
  logic m_ready = 0, m_fault = 0, m_stop = 0, m_err = 0, m_db = 0;
  int m_run = 0, m_por = 0;

  always #5 clk = ~clk;

  feed_ready_supervisor #(.DEB_CYCLES(DEB), .POR_CYCLES(POR)) i_feed_ready_supervisor (
    .clk(clk), .rst_n(rst_n), .hopper_loaded(hopper_loaded), .stacker_full(stacker_full),
    .stn1_flag(stn1_flag), .stn12_flag(stn12_flag), .manual_mode(manual_mode),
    .read_en_fail(read_en_fail), .motor_power_on(motor_power_on),
    .interlock_closed(interlock_closed), .card_stuck(card_stuck), .stop_req(stop_req),
    .ready_btn_raw(ready_btn_raw), .cycle_end(cycle_end), .resume(resume),
    .start_req(start_req), .ready(ready), .fault(fault), .motor_stop_req(motor_stop_req),
    .clear_out(clear_out), .proto_err(proto_err)
  );

  function automatic logic m_clr();
    return (m_por < POR) || m_db;
  endfunction

  function automatic logic next_ready();
    logic kill, setok;
    kill  = m_fault | manual_mode | m_stop | m_clr() | read_en_fail | !motor_power_on
          | !interlock_closed | (cycle_end & resume);
    setok = hopper_loaded & !stacker_full & stn1_flag & stn12_flag & !(m_fault | m_clr());
    return kill ? 1'b0 : (setok ? 1'b1 : m_ready);
  endfunction

  task automatic model_step();
    logic c, nr, nf, ns, ne;
    c  = m_clr();
    nr = next_ready();
    nf = c ? 1'b0 : (m_fault | !interlock_closed | card_stuck);
    ns = c ? 1'b0 : (m_stop | stop_req);
    ne = c ? 1'b0 : (m_err | (start_req & !m_ready));
    m_ready = nr; m_fault = nf; m_stop = ns; m_err = ne;
    if (ready_btn_raw == m_db) m_run = 0;
    else if (m_run == DEB - 1) begin m_run = 0; m_db = ready_btn_raw; end
    else m_run++;
    if (m_por < POR) m_por++;
  endtask

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 R2 R3 ready", ready, m_ready);
    chk("R4 fault", fault, m_fault);
    chk("R4 motor_stop_req", motor_stop_req, m_fault);
    chk("R6 R7 R8 clear_out", clear_out, m_clr());
    chk("R9 proto_err", proto_err, m_err);
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL R1 watchdog: got %0d cycles expected below 150000", wd);
      finish_run();
    end
  end

  task automatic press_and_release();
    ready_btn_raw = 1; cyc(DEB + 1);
    ready_btn_raw = 0; cyc(DEB + 1);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    @(negedge clk); @(negedge clk);
    chk("R8 reset clear_out", clear_out, 1'b1);
    chk("R8 reset ready", ready, 1'b0);
    chk("R8 reset fault", fault, 1'b0);
    chk("R8 reset proto_err", proto_err, 1'b0);
    rst_n = 1;
    cyc(POR - 1);
    chk("R8 clear still held", clear_out, 1'b1);
    cyc(1);
    chk("R8 clear released", clear_out, 1'b0);
    chk("R1 no set during clear", ready, 1'b0);
    cyc(1);
    chk("R1 ready set", ready, 1'b1);

    cycle_end = 1; cyc(1);
    chk("R2 cycle_end alone", ready, 1'b1);
    cycle_end = 0; resume = 1; cyc(1);
    chk("R2 resume alone", ready, 1'b1);
    cycle_end = 1; cyc(1);
    chk("R2 drop beats set", ready, 1'b0);
    cycle_end = 0; resume = 0; cyc(1);
    chk("R2 set again", ready, 1'b1);

    stacker_full = 1; hopper_loaded = 0; cyc(2);
    chk("R1 media loss does not drop", ready, 1'b1);
    stacker_full = 0; hopper_loaded = 1;

    start_req = 1; cyc(1);
    chk("R9 start while ready", proto_err, 1'b0);
    start_req = 0; manual_mode = 1; cyc(1);
    chk("R3 manual drops ready", ready, 1'b0);
    manual_mode = 0; start_req = 1; cyc(1);
    chk("R9 start while not ready", proto_err, 1'b1);
    start_req = 0; cyc(3);
    chk("R9 error sticky", proto_err, 1'b1);

    card_stuck = 1; cyc(1);
    chk("R4 fault on stuck card", fault, 1'b1);
    card_stuck = 0; cyc(1);
    chk("R4 fault blocks ready", ready, 1'b0);
    cyc(3);
    chk("R4 fault sticky", fault, 1'b1);

    ready_btn_raw = 1; cyc(DEB - 1);
    ready_btn_raw = 0; cyc(1);
    chk("R6 short press ignored", clear_out, 1'b0);
    chk("R6 short press keeps fault", fault, 1'b1);
    ready_btn_raw = 1; cyc(DEB);
    chk("R6 long press clears", clear_out, 1'b1);
    cyc(1);
    chk("R7 clear empties fault", fault, 1'b0);
    chk("R7 clear empties error", proto_err, 1'b0);
    ready_btn_raw = 0; cyc(DEB);
    chk("R7 clear released", clear_out, 1'b0);
    cyc(1);
    chk("R7 ready after release", ready, 1'b1);

    stop_req = 1; cyc(1);
    stop_req = 0; cyc(1);
    chk("R5 stop drops ready", ready, 1'b0);
    cyc(4);
    chk("R5 stop sticky", ready, 1'b0);
    press_and_release();
    chk("R5 stop cleared by button", ready, 1'b1);

    interlock_closed = 0; cyc(1);
    chk("R4 interlock sets fault", fault, 1'b1);
    chk("R3 interlock drops ready", ready, 1'b0);
    interlock_closed = 1;
    motor_power_on = 0; press_and_release();
    chk("R3 motor off blocks ready", ready, 1'b0);
    motor_power_on = 1; read_en_fail = 1; cyc(2);
    chk("R3 read enable failure blocks", ready, 1'b0);
    read_en_fail = 0; cyc(1);
    chk("R1 ready back", ready, 1'b1);

    for (int i = 0; i < 4000; i++) begin
      hopper_loaded    = ($urandom % 16) != 0;
      stacker_full     = ($urandom % 20) == 0;
      stn1_flag        = ($urandom % 8) != 0;
      stn12_flag       = ($urandom % 8) != 0;
      manual_mode      = ($urandom % 40) == 0;
      read_en_fail     = ($urandom % 40) == 0;
      motor_power_on   = ($urandom % 50) != 0;
      interlock_closed = ($urandom % 60) != 0;
      card_stuck       = ($urandom % 80) == 0;
      stop_req         = ($urandom % 80) == 0;
      cycle_end        = ($urandom % 4) == 0;
      resume           = ($urandom % 3) == 0;
      start_req        = ($urandom % 6) == 0;
      if (($urandom % 30) == 0) ready_btn_raw = ~ready_btn_raw;
      cyc(1);
    end
    finish_run();
  end
endmodule